// File: doc/BRIEF.md
# ADC Trigger and Readout Controller

This block drives an external 12-bit successive-approximation converter that sits behind an input multiplexer. It picks one of three trigger sources: a one-cycle software strobe, an active-low external convert pin, or an active-low periodic timer output. The two pin sources go through a synchronizer and a width qualifier. A low pulse that is long enough starts exactly one conversion. A low pulse that is too short or too long sets a sticky error flag.

Each accepted trigger produces a one-cycle start pulse towards the converter. The controller then follows the converter's busy/data handshake. When busy falls, the 12-bit result is captured and presented as a 4-bit low part and an 8-bit high part. The same capture drives a ready flag low and raises an interrupt request, and a read of the high part clears both. Triggers that arrive while a conversion is in progress are dropped. The last result stays in place until the next conversion completes, so back-to-back conversions can overlap with reading out the previous result.

Top module: `adc_trig_ctrl`

## Requirements
- R1: Only the source chosen by `trig_sel` can start a conversion. The encodings are 0 = software strobe, 1 = external pin, 2 = timer output, 3 = no source. Activity on any source that is not chosen starts nothing and raises no error.
- R2: With source 0 chosen and the controller idle, a high `sw_start` sampled at a rising edge makes `adc_start` high for exactly the following cycle.
- R3: With source 1 or 2 chosen, each pin passes through a SYNC_STAGES-flop synchronizer. A low pulse of at least MIN_CYC = ceil(MIN_LOW_NS/CLK_NS) sampled cycles (13 by default) gives exactly one `adc_start`. The start comes on the MIN_CYC-th synchronized low sample.
- R4: A chosen pin pulse that returns high after 1 to MIN_CYC-1 synchronized low samples starts no conversion and sets `width_err`.
- R5: A chosen pin that stays low for more than MAX_CYC = MAX_LOW_NS/CLK_NS samples (300 by default) sets `width_err` and still gives only one conversion. `width_err` stays set until reset.
- R6: A trigger that arrives after a start and before that conversion's result is captured is ignored. It is not queued and it does not restart the conversion.
- R7: In the cycle where `adc_busy` is sampled low after having been high for a started conversion, `adc_data` is captured. From the next cycle, `res_lo` = data[3:0] and `res_hi` = data[11:4].
- R8: A capture drives `ready_n` to 0 and `irq` to 1. A sampled `rd_hi` drives `ready_n` to 1 and `irq` to 0. When capture and `rd_hi` fall in the same cycle, the capture wins.
- R9: `res_lo`/`res_hi` keep the previous result while a new conversion is started and running, until that conversion's capture.
- R10: `mux_wr` loads `mux_wdata[3:0]` into `mux_sel` at the next rising edge.
- R11: While `rst_n` is sampled low, `adc_start`=0, `ready_n`=1, `irq`=0, `res_lo`=0, `res_hi`=0, `mux_sel`=0 and `width_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_sel | input | 2 | Trigger source choice (0 software, 1 pin, 2 timer, 3 none) |
| sw_start | input | 1 | Software start strobe, one cycle per request |
| ext_conv_n | input | 1 | External active-low convert pin (asynchronous) |
| tmr_out_n | input | 1 | Active-low periodic timer output (asynchronous) |
| mux_wr | input | 1 | Write strobe for the channel register |
| mux_wdata | input | 4 | Channel number to load |
| rd_hi | input | 1 | High-part read strobe, clears ready and interrupt |
| adc_busy | input | 1 | Converter busy flag |
| adc_data | input | 12 | Converter result, valid when busy falls |
| adc_start | output | 1 | One-cycle conversion start pulse |
| mux_sel | output | 4 | Channel number to the input multiplexer |
| res_lo | output | 4 | Result bits 3..0 |
| res_hi | output | 8 | Result bits 11..4 |
| ready_n | output | 1 | 0 when a result has arrived since the last high-part read |
| irq | output | 1 | Conversion-complete interrupt request |
| width_err | output | 1 | Sticky trigger pulse width error |

## Verification
A software strobe shows up on `adc_start` one cycle after the edge that samples it. A pin pulse shows up SYNC_STAGES + MIN_CYC edges after the first edge that samples the pin low, counting that edge as the first. Width errors appear one cycle after the edge that sees the violation. Captured data, `ready_n` and `irq` change one cycle after the edge that samples busy low, and a read clears the flags one cycle after it is sampled. The bench's behavioural model advances at every rising edge by the same edge counts. Every registered output is compared with it half a cycle later, and directed checks count start pulses per scenario.

// File: rtl/adc_trig_pkg.sv
// Shared types and helpers for the ADC trigger controller.
// Assumes: nothing beyond IEEE 1800-2017.
package adc_trig_pkg;

    typedef enum logic [1:0] {
        SRC_SW   = 2'd0,
        SRC_PIN  = 2'd1,
        SRC_TMR  = 2'd2,
        SRC_NONE = 2'd3
    } trig_src_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_CONV  = 2'd2
    } seq_state_e;

    // Integer division rounded up, for turning nanoseconds into clock counts.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/adc_pulse_qual.sv
// Synchronizes one active-low trigger pin and measures its low time.
// fire: the pulse has just reached MIN_CYC low samples (one cycle per pulse).
// bad : the pulse ended short of MIN_CYC, or has just exceeded MAX_CYC.
// Assumes: SYNC_STAGES >= 2, 1 <= MIN_CYC <= MAX_CYC.
// When en is low the counter is held at zero and both outputs are low.
module adc_pulse_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_CYC     = 13,
    parameter int MAX_CYC     = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pin_n,
    output logic fire,
    output logic bad
);
    localparam int CW = $clog2(MAX_CYC + 2);
    localparam logic [CW-1:0] MIN_M1  = CW'(MIN_CYC - 1);
    localparam logic [CW-1:0] MIN_LIM = CW'(MIN_CYC);
    localparam logic [CW-1:0] MAX_LIM = CW'(MAX_CYC);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_q;
    logic                   s_low;

    // Shift the pin through the synchronizer; idle level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
    end

    assign s_low = ~sync_q[SYNC_STAGES-1];

    // Count consecutive synchronized low samples, saturating past MAX_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)         run_q <= '0;
        else if (!s_low)           run_q <= '0;
        else if (run_q <= MAX_LIM) run_q <= run_q + 1'b1;
    end

    // Decide qualification and width violations from the current count.
    always_comb begin
        fire = en && s_low && (run_q == MIN_M1);
        bad  = en && ((s_low && (run_q == MAX_LIM)) ||
                      (!s_low && (run_q != '0) && (run_q < MIN_LIM)));
    end

endmodule

// File: rtl/adc_conv_seq.sv
// Conversion sequencer: accepts a trigger only when idle, issues a one-cycle
// start, waits for the converter's busy to rise and then fall, and flags
// the capture cycle. Triggers outside the idle state are dropped.
// Assumes: the converter raises busy some cycles after start and holds
// its data valid in the cycle where busy is first seen low.
module adc_conv_seq
    import adc_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic adc_busy,
    output logic adc_start,
    output logic cap
);
    seq_state_e state_q;

    // Advance the handshake and generate the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SEQ_IDLE;
            adc_start <= 1'b0;
        end else begin
            adc_start <= 1'b0;
            case (state_q)
                SEQ_IDLE: if (trig) begin
                    state_q   <= SEQ_ARMED;
                    adc_start <= 1'b1;
                end
                SEQ_ARMED: if (adc_busy)  state_q <= SEQ_CONV;
                SEQ_CONV:  if (!adc_busy) state_q <= SEQ_IDLE;
                default:   state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Capture strobe: busy seen low while a conversion is running.
    assign cap = (state_q == SEQ_CONV) && !adc_busy;

endmodule

// File: rtl/adc_result_regs.sv
// Result holding registers with ready flag and interrupt.
// A capture loads the split result and signals ready; a high-part read
// clears ready and the interrupt. Capture takes precedence over a read.
// Assumes: cap is a single-cycle strobe.
module adc_result_regs #(
    parameter int LO_W = 4,
    parameter int HI_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap,
    input  logic [LO_W+HI_W-1:0] cap_data,
    input  logic                 rd_hi,
    output logic [LO_W-1:0]      res_lo,
    output logic [HI_W-1:0]      res_hi,
    output logic                 ready_n,
    output logic                 irq
);
    localparam int RES_W = LO_W + HI_W;

    // Hold the most recent result until the next capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_lo <= '0;
            res_hi <= '0;
        end else if (cap) begin
            res_lo <= cap_data[LO_W-1:0];
            res_hi <= cap_data[RES_W-1:LO_W];
        end
    end

    // Ready/interrupt flags: set on capture, cleared by a high-part read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_n <= 1'b1;
            irq     <= 1'b0;
        end else if (cap) begin
            ready_n <= 1'b0;
            irq     <= 1'b1;
        end else if (rd_hi) begin
            ready_n <= 1'b1;
            irq     <= 1'b0;
        end
    end

endmodule

// File: rtl/adc_trig_ctrl.sv
// Top of the ADC trigger and readout controller.
// Picks one trigger source, qualifies pin pulses by width, runs one
// conversion per accepted trigger and holds the split result.
// Assumes: ext_conv_n and tmr_out_n are asynchronous and idle high;
// sw_start and rd_hi are one-cycle strobes in the clk domain.
module adc_trig_ctrl
    import adc_trig_pkg::*;
#(
    parameter int CLK_NS      = 20,
    parameter int MIN_LOW_NS  = 250,
    parameter int MAX_LOW_NS  = 6000,
    parameter int SYNC_STAGES = 2,
    parameter int CHAN_W      = 4,
    parameter int LO_W        = 4,
    parameter int HI_W        = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           trig_sel,
    input  logic                 sw_start,
    input  logic                 ext_conv_n,
    input  logic                 tmr_out_n,
    input  logic                 mux_wr,
    input  logic [CHAN_W-1:0]    mux_wdata,
    input  logic                 rd_hi,
    input  logic                 adc_busy,
    input  logic [LO_W+HI_W-1:0] adc_data,
    output logic                 adc_start,
    output logic [CHAN_W-1:0]    mux_sel,
    output logic [LO_W-1:0]      res_lo,
    output logic [HI_W-1:0]      res_hi,
    output logic                 ready_n,
    output logic                 irq,
    output logic                 width_err
);
    localparam int NPIN    = 2;
    localparam int MIN_CYC = ceil_div(MIN_LOW_NS, CLK_NS);
    localparam int MAX_CYC = MAX_LOW_NS / CLK_NS;

    trig_src_e        src;
    logic [NPIN-1:0]  pin_vec;
    logic [NPIN-1:0]  en_vec;
    logic [NPIN-1:0]  fire_vec;
    logic [NPIN-1:0]  bad_vec;
    logic             trig;
    logic             cap;

    assign src     = trig_src_e'(trig_sel);
    assign pin_vec = {tmr_out_n, ext_conv_n};

    // One width qualifier per pin source; index g matches encoding g+1.
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        assign en_vec[g] = (trig_sel == 2'(g + 1));
        adc_pulse_qual #(
            .SYNC_STAGES(SYNC_STAGES),
            .MIN_CYC    (MIN_CYC),
            .MAX_CYC    (MAX_CYC)
        ) u_qual (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (en_vec[g]),
            .pin_n(pin_vec[g]),
            .fire (fire_vec[g]),
            .bad  (bad_vec[g])
        );
    end

    // Merge the chosen source into a single trigger request.
    assign trig = ((src == SRC_SW) && sw_start) || (|fire_vec);

    // Sticky width error, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        width_err <= 1'b0;
        else if (|bad_vec) width_err <= 1'b1;
    end

    // Channel select register for the input multiplexer.
    always_ff @(posedge clk) begin
        if (!rst_n)      mux_sel <= '0;
        else if (mux_wr) mux_sel <= mux_wdata;
    end

    adc_conv_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .adc_busy (adc_busy),
        .adc_start(adc_start),
        .cap      (cap)
    );

    adc_result_regs #(
        .LO_W(LO_W),
        .HI_W(HI_W)
    ) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (cap),
        .cap_data(adc_data),
        .rd_hi   (rd_hi),
        .res_lo  (res_lo),
        .res_hi  (res_hi),
        .ready_n (ready_n),
        .irq     (irq)
    );

endmodule

// File: rtl/adc_trig_ctrl_chk.sv
// Property checker for adc_trig_ctrl, bound to every instance below.
// Assumes: the converter does not hold busy high while the controller idles.
module adc_trig_ctrl_chk #(
    parameter int CHAN_W = 4,
    parameter int LO_W   = 4,
    parameter int HI_W   = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mux_wr,
    input logic [CHAN_W-1:0]    mux_wdata,
    input logic                 rd_hi,
    input logic                 adc_busy,
    input logic [LO_W+HI_W-1:0] adc_data,
    input logic                 adc_start,
    input logic [CHAN_W-1:0]    mux_sel,
    input logic [HI_W-1:0]      res_hi,
    input logic [LO_W-1:0]      res_lo,
    input logic                 ready_n,
    input logic                 irq,
    input logic                 width_err
);
    localparam int RES_W = LO_W + HI_W;

    // R2: the start is a single-cycle pulse
    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    // R6: no new start while the converter is busy
    p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_busy && $past(adc_busy)) |-> !adc_start);

    // R7: a fresh result carries the data sampled at capture
    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_n) |-> (res_hi == $past(adc_data[RES_W-1:LO_W]) &&
                            res_lo == $past(adc_data[LO_W-1:0])));

    // R8: a read while busy clears ready and interrupt
    p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi && adc_busy) |=> (ready_n && !irq));

    // R9: result is held while the converter is busy
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        adc_busy |=> ($stable(res_hi) && $stable(res_lo)));

    // R5: the width error is sticky
    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        width_err |=> width_err);

    // R10: channel register loads written value
    p_mux_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mux_wr |=> (mux_sel == $past(mux_wdata)));

endmodule

bind adc_trig_ctrl adc_trig_ctrl_chk #(
    .CHAN_W(CHAN_W),
    .LO_W  (LO_W),
    .HI_W  (HI_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mux_wr   (mux_wr),
    .mux_wdata(mux_wdata),
    .rd_hi    (rd_hi),
    .adc_busy (adc_busy),
    .adc_data (adc_data),
    .adc_start(adc_start),
    .mux_sel  (mux_sel),
    .res_hi   (res_hi),
    .res_lo   (res_lo),
    .ready_n  (ready_n),
    .irq      (irq),
    .width_err(width_err)
);

// File: tb/sim_adc_trig_ctrl.sv
// Bench for adc_trig_ctrl: behavioural model stepped on each rising edge,
// all outputs compared on each falling edge, plus directed start counts.
module sim_adc_trig_ctrl;
    localparam int TCK     = 20;
    localparam int MINC    = 13;   // ceil(250/20)
    localparam int MAXC    = 300;  // 6000/20
    localparam int SYNC    = 2;
    localparam int CONV    = 20;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  trig_sel;
    logic        sw_start, ext_conv_n, tmr_out_n, mux_wr, rd_man, rd_auto, rd_hi;
    logic [3:0]  mux_wdata;
    logic        adc_busy;
    logic [11:0] adc_data;
    logic        adc_start, ready_n, irq, width_err;
    logic [3:0]  mux_sel, res_lo;
    logic [7:0]  res_hi;

    assign rd_hi = rd_man | rd_auto;

    adc_trig_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .trig_sel(trig_sel), .sw_start(sw_start),
        .ext_conv_n(ext_conv_n), .tmr_out_n(tmr_out_n), .mux_wr(mux_wr),
        .mux_wdata(mux_wdata), .rd_hi(rd_hi), .adc_busy(adc_busy),
        .adc_data(adc_data), .adc_start(adc_start), .mux_sel(mux_sel),
        .res_lo(res_lo), .res_hi(res_hi), .ready_n(ready_n), .irq(irq),
        .width_err(width_err)
    );

    always #(TCK/2) clk = ~clk;

    int    errs = 0, checks = 0, n_start = 0, adc_cnt = 0;
    string cur_req = "R11";
    logic [11:0] adc_val;
    bit    rd_at_cap = 0;
    bit    live = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---- behavioural reference model ----
    bit hq0[$];
    bit hq1[$];
    int run[2];
    int m_st;
    bit m_start, m_rdyn, m_irq, m_err;
    logic [11:0] m_res;
    logic [3:0]  m_mux;

    always @(posedge clk) begin
        bit slow[2];
        bit fire[2];
        bit bad, trig, cap;
        live = 1;
        if (!rst_n) begin
            hq0 = {}; hq1 = {};
            for (int i = 0; i < SYNC; i++) begin hq0.push_back(1'b1); hq1.push_back(1'b1); end
            run[0] = 0; run[1] = 0; m_st = 0;
            m_start = 0; m_rdyn = 1; m_irq = 0; m_err = 0; m_res = '0; m_mux = '0;
        end else begin
            slow[0] = !hq0.pop_front(); hq0.push_back(ext_conv_n);
            slow[1] = !hq1.pop_front(); hq1.push_back(tmr_out_n);
            bad = 0;
            for (int s = 0; s < 2; s++) begin
                fire[s] = 0;
                if (int'(trig_sel) != s + 1) run[s] = 0;
                else if (slow[s]) begin
                    if (run[s] == MINC - 1) fire[s] = 1;
                    if (run[s] == MAXC) bad = 1;
                    if (run[s] <= MAXC) run[s]++;
                end else begin
                    if (run[s] > 0 && run[s] < MINC) bad = 1;
                    run[s] = 0;
                end
            end
            trig = (trig_sel == 2'd0 && sw_start) || fire[0] || fire[1];
            if (bad) m_err = 1;
            if (mux_wr) m_mux = mux_wdata;
            m_start = 0; cap = 0;
            case (m_st)
                0: if (trig) begin m_st = 1; m_start = 1; end
                1: if (adc_busy) m_st = 2;
                default: if (!adc_busy) begin cap = 1; m_res = adc_data; m_st = 0; end
            endcase
            if (cap) begin m_rdyn = 0; m_irq = 1; end
            else if (rd_hi) begin m_rdyn = 1; m_irq = 0; end
        end
    end

    // ---- converter model and per-cycle comparison ----
    always @(negedge clk) begin
        if (live) begin
            chk({"start ", cur_req}, adc_start, m_start);
            chk({"R7 res_lo ", cur_req}, res_lo, m_res[3:0]);
            chk({"R7 res_hi ", cur_req}, res_hi, m_res[11:4]);
            chk({"R8 ready_n ", cur_req}, ready_n, m_rdyn);
            chk({"R8 irq ", cur_req}, irq, m_irq);
            chk("R10 mux_sel", mux_sel, m_mux);
            chk({"err ", cur_req}, width_err, m_err);
        end
        if (adc_start) n_start++;
        rd_auto = 1'b0;
        if (!rst_n) begin
            adc_cnt = 0; adc_busy = 1'b0;
        end else if (adc_cnt > 0) begin
            adc_cnt++;
            if (adc_cnt == 2) adc_busy = 1'b1;
            if (adc_cnt == 2 + CONV) begin
                adc_busy = 1'b0; adc_data = adc_val; adc_cnt = 0;
                if (rd_at_cap) rd_auto = 1'b1;
            end
        end else if (adc_start) adc_cnt = 1;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe();
        sw_start = 1'b1; cyc(1); sw_start = 1'b0;
    endtask

    task automatic pulse(input int which, input int len);
        if (which == 0) ext_conv_n = 1'b0; else tmr_out_n = 1'b0;
        cyc(len);
        ext_conv_n = 1'b1; tmr_out_n = 1'b1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(2);
    endtask

    initial begin
        #(TCK * 150000);
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int n0;
        rst_n = 1'b0; trig_sel = 2'd0; sw_start = 0; ext_conv_n = 1; tmr_out_n = 1;
        mux_wr = 0; mux_wdata = 0; rd_man = 0; rd_auto = 0; adc_busy = 0;
        adc_data = '0; adc_val = '0;
        cyc(3);
        // R11 reset state
        chk("R11 adc_start", adc_start, 0);
        chk("R11 ready_n", ready_n, 1);
        chk("R11 irq", irq, 0);
        chk("R11 result", {res_hi, res_lo}, 0);
        chk("R11 width_err", width_err, 0);
        chk("R11 mux_sel", mux_sel, 0);
        rst_n = 1'b1; cyc(2);

        cur_req = "R10";
        mux_wr = 1; mux_wdata = 4'hA; cyc(1); mux_wr = 0;
        chk("R10 mux_sel", mux_sel, 4'hA);

        cur_req = "R2"; adc_val = 12'hABC; n0 = n_start;
        strobe();
        chk("R2 start next cycle", adc_start, 1);
        cyc(40);
        chk("R2 one start", n_start - n0, 1);
        chk("R7 res_hi", res_hi, 8'hAB);
        chk("R7 res_lo", res_lo, 4'hC);
        chk("R8 ready_n after capture", ready_n, 0);
        chk("R8 irq after capture", irq, 1);
        cur_req = "R8";
        rd_man = 1; cyc(1); rd_man = 0;
        chk("R8 ready_n after read", ready_n, 1);
        chk("R8 irq after read", irq, 0);

        cur_req = "R1"; n0 = n_start;
        pulse(0, 20); pulse(1, 20); cyc(10);
        trig_sel = 2'd3; strobe(); pulse(0, 20); cyc(10);
        chk("R1 unselected sources ignored", n_start - n0, 0);
        chk("R1 no error from unselected", width_err, 0);

        cur_req = "R3"; trig_sel = 2'd1; adc_val = 12'h123; n0 = n_start;
        strobe(); cyc(5);
        chk("R1 strobe ignored on pin source", n_start - n0, 0);
        pulse(0, 20); cyc(40);
        chk("R3 pin pulse one start", n_start - n0, 1);
        chk("R3 res_hi", res_hi, 8'h12);
        chk("R3 no width error", width_err, 0);
        trig_sel = 2'd2; adc_val = 12'h456; n0 = n_start;
        pulse(1, MINC); cyc(40);
        chk("R3 timer pulse at minimum", n_start - n0, 1);
        chk("R3 res_lo", res_lo, 4'h6);

        cur_req = "R4"; trig_sel = 2'd1; n0 = n_start;
        pulse(0, MINC - 1); cyc(10);
        chk("R4 short pulse no start", n_start - n0, 0);
        chk("R4 short pulse error", width_err, 1);
        do_reset();

        cur_req = "R5"; trig_sel = 2'd2; adc_val = 12'h789; n0 = n_start;
        pulse(1, MAXC + 100); cyc(40);
        chk("R5 long pulse one start", n_start - n0, 1);
        chk("R5 long pulse error", width_err, 1);
        do_reset();

        cur_req = "R6"; trig_sel = 2'd0; adc_val = 12'hF0F; n0 = n_start;
        strobe(); strobe(); cyc(4); strobe(); cyc(8); strobe(); cyc(40);
        chk("R6 triggers while busy ignored", n_start - n0, 1);
        chk("R6 result", {res_hi, res_lo}, 12'hF0F);

        cur_req = "R9";
        rd_man = 1; cyc(1); rd_man = 0;
        adc_val = 12'h5A5; strobe(); cyc(40);
        adc_val = 12'h3C3; rd_at_cap = 1; strobe(); cyc(10);
        chk("R9 old result held", {res_hi, res_lo}, 12'h5A5);
        cyc(30); rd_at_cap = 0;
        chk("R9 new result", {res_hi, res_lo}, 12'h3C3);
        chk("R8 capture wins over read", ready_n, 0);
        chk("R8 irq kept", irq, 1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule